// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block holds the digital state for a successive approximation analog-to-digital converter. When a conversion begins, the block drives a trial word to an external DAC. On every clock it takes the result of an external comparator, fixes one result bit and moves the trial to the next lower bit. The trial word and the finished result use the same parallel output. Each decided bit also leaves on a serial output, MSB first, together with a valid strobe. A done flag rises when the last bit is fixed.

A stop input ends a conversion early, so a shorter result can be used. A synchronous hold-clear input lets several units be chained for wider results. In a chain, the upper unit's done flag drives the lower unit's start input. The upper unit's start pulse holds the lower unit clear. Because start acts on its rising edge, a done flag that stays high does not restart a conversion over and over. A new rising edge of start during a conversion restarts it from the MSB.

Top module: `sar_ctrl`

## Requirements
- R1: While the asynchronous active-low reset `rst_n` is low, `data_o` is 0 and `busy_o`, `eoc_o` and `ser_vld_o` are all 0.
- R2: `clr_i` is synchronous and has the highest priority. At every edge where it is high, `data_o` becomes 0 and `busy_o`, `eoc_o` and `ser_vld_o` become 0. A rising `start_i` at that edge is ignored.
- R3: A start event is an edge where `start_i` is high and was low at the previous edge. At a start event, `data_o` becomes a word with only the MSB set (0x80 for WIDTH 8), `busy_o` becomes 1 and `eoc_o` becomes 0. This also applies in the middle of a conversion, which restarts from the MSB.
- R4: At each edge while busy and without a start event, one bit is decided, with bits taken from MSB down to LSB. The bit under trial takes the value of `cmp_i`, which is 1 when the analog input is at or above the DAC level. The next lower bit is set to 1 as the new trial. After a full conversion, `data_o` equals the analog code.
- R5: Without a stop request, `eoc_o` rises and `busy_o` falls at the WIDTH-th edge after the start event. `eoc_o` and `data_o` then hold until the next start event or clear. `eoc_o` and `busy_o` are never high together.
- R6: If `stop_i` is high at a deciding edge, that decision is the last one. The lower bits stay 0, and `eoc_o` rises and `busy_o` falls at that same edge.
- R7: At each deciding edge, `ser_o` takes the decided bit and `ser_vld_o` is high for the following cycle. In any other cycle `ser_vld_o` is low. The bits therefore leave MSB first.
- R8: Holding `start_i` high for many cycles gives only one start event. The conversion runs to its end, and `eoc_o` then stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acts on its rising edge |
| clr_i | input | 1 | Synchronous hold-clear, used for cascading |
| stop_i | input | 1 | Ends the conversion after the current decision |
| cmp_i | input | 1 | Comparator result, 1 when the analog input is at or above the DAC level |
| data_o | output | WIDTH | Trial word to the DAC; the result once done |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | Conversion complete |
| ser_o | output | 1 | Most recently decided bit |
| ser_vld_o | output | 1 | `ser_o` holds a newly decided bit |

## Verification
The bench builds the block at WIDTH 8, the default. At this width all 256 analog codes can be swept, each through a full eight-step conversion with a check of the serial stream. A stop request is placed at each of the first seven decision positions. A restart at mid-conversion, a clear that arrives together with a start edge, and a start held high are also covered. Each is compared cycle by cycle against a behavioural model.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_st_e;
endpackage

// File: rtl/sar_seq.sv
// Sequencer: start edge detection, bit pointer, busy/done state.
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          clr_i,
  input  logic          stop_i,
  output logic          load_o,
  output logic          dec_o,
  output logic          last_o,
  output logic [PW-1:0] ptr_o,
  output logic          busy_o,
  output logic          eoc_o
);
  sar_st_e       st_q, st_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          eoc_q, eoc_d;
  logic          start_q;
  logic          rise;

  always_comb begin
    rise   = start_i & ~start_q;
    load_o = ~clr_i & rise;
    dec_o  = ~clr_i & ~rise & (st_q == ST_CONV);
    last_o = dec_o & ((ptr_q == '0) | stop_i);
  end

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    eoc_d = eoc_q;
    if (clr_i) begin
      st_d  = ST_IDLE;
      eoc_d = 1'b0;
    end else if (load_o) begin
      st_d  = ST_CONV;
      ptr_d = PW'(WIDTH - 1);
      eoc_d = 1'b0;
    end else if (dec_o) begin
      if (last_o) begin
        st_d  = ST_IDLE;
        eoc_d = 1'b1;
      end else begin
        ptr_d = ptr_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      eoc_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      eoc_q   <= eoc_d;
      start_q <= start_i;
    end
  end

  assign ptr_o  = ptr_q;
  assign busy_o = (st_q == ST_CONV);
  assign eoc_o  = eoc_q;
endmodule

// File: rtl/sar_reg.sv
// Trial/result register, one enabled flop per bit.
module sar_reg #(
  parameter int WIDTH = 8,
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic             last_i,
  input  logic [PW-1:0]    ptr_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] data_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic hit, below, en, d, q;

    always_comb begin
      hit   = (int'(ptr_i) == i);
      below = (int'(ptr_i) == i + 1);
      en    = clr_i | load_i | (dec_i & (hit | (below & ~last_i)));
      if (clr_i)            d = 1'b0;
      else if (load_i)      d = (i == WIDTH - 1);
      else if (dec_i & hit) d = cmp_i;
      else                  d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end

    assign data_o[i] = q;
  end
endmodule

// File: rtl/sar_ser.sv
// Serial output of each decided bit with a one-cycle strobe.
module sar_ser (
  input  logic clk,
  input  logic rst_n,
  input  logic dec_i,
  input  logic cmp_i,
  output logic ser_o,
  output logic vld_o
);
  logic ser_q, vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= dec_i;
      if (dec_i) ser_q <= cmp_i;
    end
  end

  assign ser_o = ser_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             clr_i,
  input  logic             stop_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] data_o,
  output logic             busy_o,
  output logic             eoc_o,
  output logic             ser_o,
  output logic             ser_vld_o
);
  localparam int PW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic          load, dec, last;
  logic [PW-1:0] ptr;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_i(clr_i), .stop_i(stop_i),
    .load_o(load), .dec_o(dec), .last_o(last), .ptr_o(ptr),
    .busy_o(busy_o), .eoc_o(eoc_o)
  );

  sar_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .load_i(load), .dec_i(dec),
    .last_i(last), .ptr_i(ptr), .cmp_i(cmp_i), .data_o(data_o)
  );

  sar_ser u_ser (
    .clk(clk), .rst_n(rst_n), .dec_i(dec), .cmp_i(cmp_i),
    .ser_o(ser_o), .vld_o(ser_vld_o)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             clr_i,
  input logic             stop_i,
  input logic             cmp_i,
  input logic [WIDTH-1:0] data_o,
  input logic             busy_o,
  input logic             eoc_o,
  input logic             ser_o,
  input logic             ser_vld_o
);
  localparam logic [WIDTH-1:0] MSB = {1'b1, {(WIDTH-1){1'b0}}};

  logic sq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sq <= 1'b0;
    else        sq <= start_i;
  end

  logic ev;
  assign ev = start_i & ~sq;

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (data_o == '0 && !busy_o && !eoc_o && !ser_vld_o));

  p_clr_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (data_o == '0 && !busy_o && !eoc_o && !ser_vld_o));

  p_start_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && ev) |=> (data_o == MSB && busy_o && !eoc_o));

  p_eoc_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoc_o && busy_o));

  p_eoc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc_o && !clr_i && !ev) |=> (eoc_o && $stable(data_o)));

  p_stop_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && stop_i && !clr_i && !ev) |=> (eoc_o && !busy_o));

  p_ser_vld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !clr_i && !ev) |=> (ser_vld_o && ser_o == cmp_i ? 1'b1 : ser_vld_o));

  p_ser_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o || clr_i || ev) |=> !ser_vld_o);

  p_held_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !clr_i && start_i && sq) |=> (!busy_o && $stable(data_o)));
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_i(clr_i), .stop_i(stop_i),
  .cmp_i(cmp_i), .data_o(data_o), .busy_o(busy_o), .eoc_o(eoc_o),
  .ser_o(ser_o), .ser_vld_o(ser_vld_o)
);

// File: tb/sar_ctrl_tb.sv
module sar_ctrl_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, start, clr, stop;
  logic [W-1:0] ana;
  logic         cmp;
  logic [W-1:0] data;
  logic         busy, eoc, ser, vld;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  assign cmp = (ana >= data);

  sar_ctrl #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .clr_i(clr), .stop_i(stop),
    .cmp_i(cmp), .data_o(data), .busy_o(busy), .eoc_o(eoc),
    .ser_o(ser), .ser_vld_o(vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_data;
  bit m_busy, m_eoc, m_ser, m_vld, m_sq;
  int m_ptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data = '0; m_busy = 0; m_eoc = 0; m_vld = 0; m_ser = 0; m_sq = 0; m_ptr = 0;
    end else begin
      bit rise;
      rise = start && !m_sq;
      m_sq = start;
      if (clr) begin
        m_data = '0; m_busy = 0; m_eoc = 0; m_vld = 0;
      end else if (rise) begin
        m_data = '0; m_data[W-1] = 1'b1; m_busy = 1; m_eoc = 0; m_vld = 0; m_ptr = W-1;
      end else if (m_busy) begin
        m_data[m_ptr] = cmp; m_ser = cmp; m_vld = 1;
        if (m_ptr == 0 || stop) begin
          m_busy = 0; m_eoc = 1;
        end else begin
          m_data[m_ptr-1] = 1'b1;
          m_ptr--;
        end
      end else begin
        m_vld = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(data == m_data, "R4 data", data, m_data);
      chk(busy == m_busy, "R3 busy", busy, m_busy);
      chk(eoc == m_eoc, "R5 eoc", eoc, m_eoc);
      chk(vld == m_vld, "R7 ser_vld", vld, m_vld);
      if (m_vld) chk(ser == m_ser, "R7 ser", ser, m_ser);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  // start pulse at a negedge; returns at the negedge where busy is first seen
  task automatic kick();
    start = 1'b1; tick(); start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; start = 0; clr = 0; stop = 0; ana = '0;
    repeat (3) tick();
    chk(data == 0 && !busy && !eoc && !vld, "R1 reset", {busy, eoc, vld, data}, 0);
    rst_n = 1'b1;
    tick();

    // R4/R5/R7: sweep every code
    for (int a = 0; a < (1 << W); a++) begin
      logic [W-1:0] sbits;
      int n;
      ana = W'(a);
      kick();
      chk(busy && data == {1'b1, {(W-1){1'b0}}}, "R3 load", data, 8'h80);
      sbits = '0; n = 0;
      for (int k = 0; k < W; k++) begin
        chk(!eoc, "R5 early eoc", eoc, 0);
        tick();
        if (vld) begin sbits = {sbits[W-2:0], ser}; n++; end
      end
      chk(eoc && !busy, "R5 eoc at WIDTH", {eoc, busy}, 2'b10);
      chk(data == W'(a), "R4 result", data, a);
      chk(n == W && sbits == W'(a), "R7 serial msb first", sbits, a);
      tick();
      chk(eoc && data == W'(a), "R5 hold", data, a);
    end

    // R6: stop after decision j
    for (int j = 0; j < W - 1; j++) begin
      logic [W-1:0] exp;
      ana = '1;
      kick();
      repeat (j) tick();
      stop = 1'b1; tick(); stop = 1'b0;
      exp = '0;
      for (int b = 0; b <= j; b++) exp[W-1-b] = 1'b1;
      chk(eoc && !busy, "R6 stop eoc", {eoc, busy}, 2'b10);
      chk(data == exp, "R6 lower bits zero", data, exp);
      repeat (2) tick();
      chk(data == exp && eoc, "R6 hold", data, exp);
    end

    // R3: retrigger in mid conversion
    ana = 8'h3C;
    kick();
    repeat (4) tick();
    start = 1'b1; tick(); start = 1'b0;
    chk(busy && data == 8'h80, "R3 retrigger", data, 8'h80);
    repeat (W) tick();
    chk(eoc && data == 8'h3C, "R3 retrigger result", data, 8'h3C);

    // R2: clear with simultaneous start edge, held with start toggling
    ana = 8'h5A;
    kick();
    repeat (3) tick();
    clr = 1'b1; start = 1'b1; tick();
    chk(data == 0 && !busy && !eoc, "R2 clr wins", {busy, eoc, data}, 0);
    start = 1'b0; tick(); start = 1'b1; tick();
    chk(data == 0 && !busy && !eoc, "R2 clr held", {busy, eoc, data}, 0);
    start = 1'b0; clr = 1'b0; tick();
    chk(!busy && data == 0, "R2 idle after clr", data, 0);

    // R8: start held high
    ana = 8'hC3;
    start = 1'b1;
    repeat (W + 1) tick();
    chk(eoc && data == 8'hC3, "R8 single conversion", data, 8'hC3);
    repeat (5) tick();
    chk(eoc && !busy && data == 8'hC3, "R8 no retrigger", data, 8'hC3);
    start = 1'b0;
    repeat (2) tick();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule